// File: doc/BRIEF.md
# Serial Transmitter with Break Generator

This block sends bytes on an asynchronous serial line using eight data bits, no parity and one stop bit. A processor writes a byte into a one-deep holding register. The byte moves into a shifter when the line is free. An external one-cycle enable pulse, `bit_tick`, paces every bit, so the baud-rate divider stays outside this block.

Two status flags are visible in an 8-bit status word:
- **Holding-register-empty** is bit 7.
- **Line-complete** is bit 6.

Software clears both flags with a two-step handshake: read the status, then write the data register.

A control write can request a line break, which holds the line low for a whole character. The break repeats for as long as the request bit stays set. When the transmitter is enabled, it first sends one idle character of high bits before anything else.

Top module: `async_tx_unit`

## Requirements
- R1: After reset the status word reads 0xC0: bit 7 holding-empty is 1, bit 6 line-complete is 1, and bits 5..0 are 0. `txd` is high.
- R2: A data frame is a low start bit, then the eight data bits least significant first, then a high stop bit.
  - Each bit lasts from one `bit_tick` to the next.
  - `txd` changes only in the cycle after a tick.
- R3: When `tx_en` rises, the block queues 10 high bit times, which is one idle character, ahead of any other frame. No frame starts while `tx_en` is low.
- R4: A pending byte enters the shifter on the first tick at which the shifter is idle or is ending its last bit. That transfer sets holding-empty, so frames can run back to back with no gap.
- R5: Line-complete is set on the tick that ends the last frame when nothing else is queued.
- R6: Both flags are cleared only by a data write that follows a status read.
  - The status read arms a one-bit latch.
  - A control write in between does not disarm it.
  - Every data write consumes the arm.
  - An unarmed data write, or the start of a break or idle character, leaves both flags unchanged.
- R7: Writing 1 to the break bit queues one break character: 10 bit times low, then one high bit time. This holds even if the bit is written back to 0 before the next tick.
- R8: While the break bit stays 1, break characters follow each other back to back. Clearing the bit during a break lets that break finish, and then the line goes idle.
- R9: When several frames are waiting at a start tick, the idle character goes first, then a break, then data.
- R10: When an armed data write falls in the same cycle as a flag-setting event (a byte transfer or the end of the line activity), the clear wins. The written byte stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge queues the idle character |
| data_wr | input | 1 | Write strobe for the data register |
| data_in | input | 8 | Byte written with `data_wr` |
| ctrl_wr | input | 1 | Write strobe for the break control bit |
| brk_bit | input | 1 | Break bit value written with `ctrl_wr` |
| stat_rd | input | 1 | Status read strobe; arms the clear handshake |
| stat_out | output | 8 | Status word: bit 7 holding-empty, bit 6 line-complete |
| txd | output | 1 | Serial line, high when idle |

## Verification
Two collisions can happen in a single cycle.
- **Flag clear against line-complete set.** An armed data write is driven in the same cycle as the tick that ends a frame with nothing queued. The pass criterion is a status of 0x00 straight afterwards.
- **Flag clear against holding-empty set.** An armed data write lands on the tick that moves the previous pending byte into the shifter. The status must read 0x00 and the line must show the start bit of the older byte. The newer byte must follow it with no gap.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int TXB_DW = 8;
  localparam int STAT_W = 8;
  localparam int IDX_W  = $clog2(TXB_DW + 3);

  localparam logic [IDX_W-1:0] LAST_CHAR = IDX_W'(TXB_DW + 1);
  localparam logic [IDX_W-1:0] LAST_BRK  = IDX_W'(TXB_DW + 2);

  typedef enum logic [1:0] {FK_NONE, FK_PRE, FK_BRK, FK_DAT} frame_kind_e;

  // index of the final bit slot of a frame kind
  function automatic logic [IDX_W-1:0] last_idx(frame_kind_e k);
    return (k == FK_BRK) ? LAST_BRK : LAST_CHAR;
  endfunction

  // line level for slot idx of a frame kind
  function automatic logic frame_bit(frame_kind_e k, logic [IDX_W-1:0] idx,
                                     logic [TXB_DW-1:0] d);
    logic [TXB_DW-1:0] sh;
    sh = d >> (idx - 1'b1);
    case (k)
      FK_BRK:  return idx == LAST_BRK;
      FK_DAT:  begin
        if (idx == '0) return 1'b0;
        if (idx == LAST_CHAR) return 1'b1;
        return sh[0];
      end
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/txb_queue.sv
module txb_queue
  import txb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              wr_data_i,
  input  logic [TXB_DW-1:0] wr_byte_i,
  input  logic              wr_ctrl_i,
  input  logic              ctrl_brk_i,
  input  logic              slot_i,
  output frame_kind_e       kind_o,
  output logic [TXB_DW-1:0] byte_o,
  output logic              take_o,
  output logic              xfer_o
);
  logic              en_q, pre_pend_q, brk_ctl_q, brk_req_q, hold_vld_q;
  logic [TXB_DW-1:0] hold_q;
  logic              pre_want;

  assign pre_want = pre_pend_q || !en_q;

  always_comb begin
    if (!tx_en_i)                   kind_o = FK_NONE;
    else if (pre_want)              kind_o = FK_PRE;
    else if (brk_req_q || brk_ctl_q) kind_o = FK_BRK;
    else if (hold_vld_q)            kind_o = FK_DAT;
    else                            kind_o = FK_NONE;
  end

  assign byte_o = hold_q;
  assign take_o = slot_i && (kind_o != FK_NONE);
  assign xfer_o = take_o && (kind_o == FK_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      pre_pend_q <= 1'b0;
      brk_ctl_q  <= 1'b0;
      brk_req_q  <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      en_q <= tx_en_i;
      if (!tx_en_i)                           pre_pend_q <= 1'b0;
      else if (take_o && kind_o == FK_PRE)    pre_pend_q <= 1'b0;
      else if (!en_q)                         pre_pend_q <= 1'b1;
      if (wr_ctrl_i) brk_ctl_q <= ctrl_brk_i;
      if (wr_ctrl_i && ctrl_brk_i)            brk_req_q <= 1'b1;
      else if (take_o && kind_o == FK_BRK)    brk_req_q <= 1'b0;
      if (wr_data_i) begin
        hold_q     <= wr_byte_i;
        hold_vld_q <= 1'b1;
      end else if (xfer_o) begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  // R9
  data_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> (en_q && !pre_pend_q && !brk_req_q && !brk_ctl_q));

  // R3
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_i && !en_q) |-> !take_o);
endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
  import txb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  frame_kind_e       kind_i,
  input  logic [TXB_DW-1:0] byte_i,
  input  logic              take_i,
  output logic              slot_o,
  output logic              idle_evt_o,
  output logic              txd_o
);
  frame_kind_e       kind_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TXB_DW-1:0] dat_q;
  logic              busy_w, last_w;

  assign busy_w     = (kind_q != FK_NONE);
  assign last_w     = busy_w && (idx_q == last_idx(kind_q));
  assign slot_o     = tick_i && (!busy_w || last_w);
  assign idle_evt_o = tick_i && last_w && !take_i;
  assign txd_o      = frame_bit(kind_q, idx_q, dat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= FK_NONE;
      idx_q  <= '0;
      dat_q  <= '0;
    end else if (slot_o) begin
      idx_q <= '0;
      if (take_i) begin
        kind_q <= kind_i;
        dat_q  <= byte_i;
      end else begin
        kind_q <= FK_NONE;
      end
    end else if (tick_i && busy_w) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // R2
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(txd_o));

  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == FK_BRK && idx_q != LAST_BRK) |-> !txd_o);

  // R4
  idx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (idx_q <= last_idx(kind_q)));
endmodule

// File: rtl/txb_flags.sv
module txb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stat_i,
  input  logic wr_data_i,
  input  logic xfer_i,
  input  logic idle_evt_i,
  output logic dre_o,
  output logic tc_o
);
  logic arm_q, dre_q, tc_q, clr_w;

  assign clr_w = wr_data_i && arm_q;
  assign dre_o = dre_q;
  assign tc_o  = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      dre_q <= 1'b1;
      tc_q  <= 1'b1;
    end else begin
      if (rd_stat_i)      arm_q <= 1'b1;
      else if (wr_data_i) arm_q <= 1'b0;
      if (clr_w)          dre_q <= 1'b0;
      else if (xfer_i)    dre_q <= 1'b1;
      if (clr_w)          tc_q  <= 1'b0;
      else if (idle_evt_i) tc_q <= 1'b1;
    end
  end

  // R6
  unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && !arm_q && !xfer_i && !idle_evt_i) |=> ($stable(dre_q) && $stable(tc_q)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && arm_q) |=> (!dre_q && !tc_q));
endmodule

// File: rtl/async_tx_unit.sv
module async_tx_unit
  import txb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              data_wr,
  input  logic [TXB_DW-1:0] data_in,
  input  logic              ctrl_wr,
  input  logic              brk_bit,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_out,
  output logic              txd
);
  frame_kind_e       q_kind;
  logic [TXB_DW-1:0] q_byte;
  logic              q_take, q_xfer, sh_slot, sh_idle_evt, f_dre, f_tc;

  txb_queue u_queue (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en),
    .wr_data_i(data_wr), .wr_byte_i(data_in),
    .wr_ctrl_i(ctrl_wr), .ctrl_brk_i(brk_bit),
    .slot_i(sh_slot), .kind_o(q_kind), .byte_o(q_byte),
    .take_o(q_take), .xfer_o(q_xfer)
  );

  txb_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .tick_i(bit_tick),
    .kind_i(q_kind), .byte_i(q_byte), .take_i(q_take),
    .slot_o(sh_slot), .idle_evt_o(sh_idle_evt), .txd_o(txd)
  );

  txb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .rd_stat_i(stat_rd), .wr_data_i(data_wr),
    .xfer_i(q_xfer), .idle_evt_i(sh_idle_evt),
    .dre_o(f_dre), .tc_o(f_tc)
  );

  assign stat_out = {f_dre, f_tc, {(STAT_W-2){1'b0}}};

  // R5
  complete_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_tc) |-> $past(sh_idle_evt));

  // R4
  empty_set_by_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_dre) |-> $past(q_xfer));
endmodule

// File: tb/test_async_tx_unit.sv
module test_async_tx_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, tx_en = 1'b1, data_wr = 1'b0, ctrl_wr = 1'b0;
  logic       brk_bit = 1'b0, stat_rd = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] stat_out;
  logic       txd;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  async_tx_unit i_async_tx_unit (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .data_wr(data_wr), .data_in(data_in), .ctrl_wr(ctrl_wr), .brk_bit(brk_bit),
    .stat_rd(stat_rd), .stat_out(stat_out), .txd(txd)
  );

  localparam logic [10:0] PRE_V = 11'h7FF;
  localparam logic [10:0] BRK_V = 11'b100_0000_0000;
  function automatic logic [10:0] dat_v(logic [7:0] b);
    return {2'b11, b, 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_bit();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    @(negedge clk);
  endtask
  task automatic pulse_rd();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask
  task automatic pulse_wr(logic [7:0] b);
    @(negedge clk) begin data_wr = 1'b1; data_in = b; end
    @(negedge clk) data_wr = 1'b0;
  endtask
  task automatic pulse_ctrl(logic v);
    @(negedge clk) begin ctrl_wr = 1'b1; brk_bit = v; end
    @(negedge clk) ctrl_wr = 1'b0;
  endtask
  task automatic tick_with_write(logic [7:0] b);
    @(negedge clk) begin bit_tick = 1'b1; data_wr = 1'b1; data_in = b; end
    @(negedge clk) begin bit_tick = 1'b0; data_wr = 1'b0; end
    @(negedge clk);
  endtask
  task automatic expect_bits(string tag, logic [10:0] v, int lo, int hi);
    for (int i = lo; i <= hi; i++) begin
      step_bit();
      chk(tag, {7'd0, txd}, {7'd0, v[i]});
    end
  endtask

  task automatic t_reset();
    chk("R1 status", stat_out, 8'hC0);
    chk("R1 txd", {7'd0, txd}, 8'd1);
  endtask

  task automatic t_first_frame();
    pulse_rd(); pulse_wr(8'hA5);
    chk("R6 armed clear", stat_out, 8'h00);
    expect_bits("R3 preamble", PRE_V, 0, 9);
    chk("R3 data held behind preamble", stat_out, 8'h00);
    expect_bits("R2 frame A5", dat_v(8'hA5), 0, 9);
    chk("R4 transfer sets empty", stat_out, 8'h80);
    step_bit();
    chk("R5 complete after frame", stat_out, 8'hC0);
  endtask

  task automatic t_unarmed();
    pulse_wr(8'h3C);
    chk("R6 unarmed write", stat_out, 8'hC0);
    expect_bits("R2 frame 3C", dat_v(8'h3C), 0, 9);
    step_bit();
    pulse_rd(); pulse_ctrl(1'b0); pulse_wr(8'hE1);
    chk("R6 arm survives ctrl write", stat_out, 8'h00);
    expect_bits("R2 frame E1", dat_v(8'hE1), 0, 9);
    step_bit();
    chk("R5 idle again", stat_out, 8'hC0);
  endtask

  task automatic t_single_break();
    pulse_ctrl(1'b1); pulse_ctrl(1'b0);
    expect_bits("R7 one break", BRK_V, 0, 10);
    step_bit();
    chk("R7 no second break", {7'd0, txd}, 8'd1);
    step_bit();
    chk("R7 line idle", {7'd0, txd}, 8'd1);
    chk("R6 break leaves flags", stat_out, 8'hC0);
  endtask

  task automatic t_held_break();
    pulse_ctrl(1'b1);
    expect_bits("R8 break 1", BRK_V, 0, 10);
    expect_bits("R8 break 2 head", BRK_V, 0, 5);
    pulse_ctrl(1'b0);
    expect_bits("R8 break 2 tail", BRK_V, 6, 10);
    step_bit();
    chk("R8 idle after clear", {7'd0, txd}, 8'd1);
    chk("R6 flags after breaks", stat_out, 8'hC0);
  endtask

  task automatic t_priority();
    pulse_rd(); pulse_wr(8'h5A); pulse_ctrl(1'b1); pulse_ctrl(1'b0);
    expect_bits("R9 break first", BRK_V, 0, 10);
    chk("R9 data still pending", stat_out, 8'h00);
    expect_bits("R9 data second", dat_v(8'h5A), 0, 9);
    step_bit();
    chk("R5 after priority", stat_out, 8'hC0);
  endtask

  task automatic t_collide_complete();
    pulse_rd(); pulse_wr(8'h81);
    expect_bits("R2 frame 81", dat_v(8'h81), 0, 9);
    pulse_rd();
    tick_with_write(8'h7E);
    chk("R10 clear beats complete", stat_out, 8'h00);
    chk("R10 line idle", {7'd0, txd}, 8'd1);
    expect_bits("R10 frame 7E", dat_v(8'h7E), 0, 9);
    chk("R4 7E transferred", stat_out, 8'h80);
    step_bit();
    chk("R5 after 7E", stat_out, 8'hC0);
  endtask

  task automatic t_collide_xfer();
    pulse_rd(); pulse_wr(8'h11);
    expect_bits("R2 frame 11 head", dat_v(8'h11), 0, 4);
    pulse_rd(); pulse_wr(8'h22);
    chk("R6 second byte pending", stat_out, 8'h00);
    expect_bits("R2 frame 11 tail", dat_v(8'h11), 5, 9);
    pulse_rd();
    tick_with_write(8'h33);
    chk("R10 clear beats transfer", stat_out, 8'h00);
    chk("R4 chained start bit", {7'd0, txd}, 8'd0);
    expect_bits("R4 frame 22", dat_v(8'h22), 1, 9);
    expect_bits("R4 frame 33", dat_v(8'h33), 0, 9);
    chk("R4 33 transferred", stat_out, 8'h80);
    step_bit();
    chk("R5 after chain", stat_out, 8'hC0);
  endtask

  task automatic t_enable();
    @(negedge clk) tx_en = 1'b0;
    pulse_rd(); pulse_wr(8'h96);
    for (int i = 0; i < 3; i++) begin
      step_bit();
      chk("R3 no start while disabled", {7'd0, txd}, 8'd1);
    end
    chk("R3 byte held while disabled", stat_out, 8'h00);
    @(negedge clk) tx_en = 1'b1;
    expect_bits("R3 preamble on enable", PRE_V, 0, 9);
    chk("R3 byte after preamble", stat_out, 8'h00);
    expect_bits("R2 frame 96", dat_v(8'h96), 0, 9);
    step_bit();
    chk("R5 after enable", stat_out, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_unarmed();
    t_single_break();
    t_held_break();
    t_priority();
    t_collide_complete();
    t_collide_xfer();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule